// File: doc/BRIEF.md
# Interprocessor Mailbox Register Block

This block is a memory-mapped peripheral that lets several processors pass 32-bit words to one another. It holds a set of message queues. A sender writes a word into a queue's message register. A receiver reads the same register to take the oldest word off the queue. Per-queue registers report how many words are waiting and whether the queue is full.

Each queue produces two events. A new-message event fires when a word lands in an empty queue. A not-full event fires when a word is taken from a full queue. Every user (processor) has its own interrupt status register and interrupt enable register. Both events of every queue are recorded in every user's status register, so each user picks the events it cares about through its enable mask. As a result, one queue can interrupt the receiving processor on new data and interrupt the sending processor when space frees up.

The block also holds a configuration register with two idle-control fields that are stored only. Writing the configuration register's reset bit starts a soft reset that lasts a fixed number of cycles and is reported through a status bit. All access goes through a simple register port (address, write enable, write data, read enable, read data). Reads are combinational in the cycle `rd_en` is high. Writes and pops take effect at the clock edge that ends that cycle.

Top module: `mbox_regblk`

## Requirements
- R1: After `rst_n` is released, every queue is empty, every status and enable register reads 0, every `irq_o` bit is 0, system status (0x014) bit 0 reads 1, and the revision register (0x000) reads 0x21 (major 2 in bits 7:4, minor 1 in bits 3:0).
- R2: A write to 0x040+4*m appends the word to queue m (m in 0..3). A read of that address returns the oldest word and removes it, so words leave in the order they were written.
- R3: The word at 0x0C0+4*m reads the number of words in queue m (0 to 4). The word at 0x080+4*m reads 1 when queue m holds 4 words and 0 otherwise.
- R4: A write to a full queue is dropped. A read of an empty queue returns 0. Neither changes the queue's contents or count.
- R5: A write accepted into an empty queue m sets bit 2*m of every user's status register (user u at 0x100+8*u).
- R6: A read that takes a word from a full queue m sets bit 2*m+1 of every user's status register.
- R7: Writing a status register clears each bit written as 1 and leaves each bit written as 0. Status bits otherwise only clear through a soft reset.
- R8: The enable register of user u (0x104+8*u) stores bits 7:0 of the written word and reads them back, with bits 31:8 reading 0.
- R9: `irq_o[u]` is high exactly when user u's status and enable registers share a set bit. It follows register changes with no added delay.
- R10: Configuration (0x010) stores bit 0 and bits 4:3 and reads them back, with bit 1 reading 0. Writing it with bit 1 set clears all queues, status, enable and configuration bits. For the next 4 cycles, system status bit 0 reads 0 and all writes and pops are ignored.
- R11: A read of an unmapped or non-word-aligned address returns 0, and a write to one has no effect. When `wr_en` and `rd_en` are high in the same cycle, the write takes effect and no pop occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 9 | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pops when aimed at a message register |
| rd_data | output | 32 | Read data, combinational while `rd_en` is high, 0 otherwise |
| irq_o | output | 4 | One interrupt line per user |

## Verification
The bench aims at the queue edges: the fifth write into a four-deep queue and a read from an empty one. A design that mishandled these would corrupt the count, overwrite the oldest word, or return stale data instead of 0. It checks that a new-message event fires only on the empty-to-non-empty step, and a not-full event only on the full-to-not-full step. A design that raised events on every push or pop would leave status bits set that the reference model expects clear. During soft reset it probes system status bit 0 and attempts pushes. A design that accepted those writes, or whose busy window had the wrong length, would show a non-zero count or the wrong status reading. Long random traffic over every queue, status and enable register is compared each cycle, including `irq_o`, which exposes any event routed to the wrong bit or user.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_REV, RG_CFG, RG_STS, RG_MSG, RG_FULL, RG_CNT, RG_IST, RG_IEN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } reg_sel_t;

  // event bit positions inside a user's status/enable word
  function automatic int newmsg_bit(input int q);
    return 2 * q;
  endfunction

  function automatic int notfull_bit(input int q);
    return 2 * q + 1;
  endfunction

  // byte address -> register kind and index (R11: misaligned/unmapped -> none)
  function automatic reg_sel_t decode(input logic [15:0] a, input int nq, input int nu);
    reg_sel_t s;
    int off;
    s.kind = RG_NONE;
    s.idx  = '0;
    off    = int'(a);
    if (a[1:0] == 2'b00) begin
      if (off == 'h000)                          s.kind = RG_REV;
      else if (off == 'h010)                     s.kind = RG_CFG;
      else if (off == 'h014)                     s.kind = RG_STS;
      else if (off >= 'h040 && off < 'h040 + 4*nq) begin
        s.kind = RG_MSG;  s.idx = 4'((off - 'h040) >> 2);
      end else if (off >= 'h080 && off < 'h080 + 4*nq) begin
        s.kind = RG_FULL; s.idx = 4'((off - 'h080) >> 2);
      end else if (off >= 'h0C0 && off < 'h0C0 + 4*nq) begin
        s.kind = RG_CNT;  s.idx = 4'((off - 'h0C0) >> 2);
      end else if (off >= 'h100 && off < 'h100 + 8*nu) begin
        s.kind = a[2] ? RG_IEN : RG_IST;
        s.idx  = 4'((off - 'h100) >> 3);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            push,
  input  logic                            pop,
  input  logic [DW-1:0]                   din,
  output logic [DW-1:0]                   head,
  output logic [$clog2(DEPTH+1)-1:0]      count,
  output logic                            full,
  output logic                            empty,
  output logic                            went_nonempty,
  output logic                            left_full
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST     = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full          = (count == FULL_CNT);
  assign empty         = (count == '0);
  assign push_ok       = push && !full;     // R4: drop when full
  assign pop_ok        = pop && !empty;     // R4: nothing when empty
  assign went_nonempty = push_ok && empty;  // R5 event
  assign left_full     = pop_ok && full;    // R6 event
  assign head          = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [NB-1:0] ev,
  input  logic          st_we,
  input  logic          en_we,
  input  logic [NB-1:0] wdata,
  output logic [NB-1:0] st,
  output logic [NB-1:0] en,
  output logic          irq
);
  logic [NB-1:0] clr_mask;

  assign clr_mask = st_we ? wdata : '0;   // R7: write-one-to-clear
  assign irq      = |(st & en);           // R9

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
      en <= '0;
    end else if (clr) begin
      st <= '0;
      en <= '0;
    end else begin
      st <= (st & ~clr_mask) | ev;        // an event in the same cycle wins
      if (en_we) en <= wdata;             // R8
    end
  end
endmodule

// File: rtl/mbox_srst.sv
module mbox_srst #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= CW'(CYCLES);
    else if (busy)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/mbox_regblk.sv
module mbox_regblk
  import mbox_pkg::*;
#(
  parameter int NQ         = 4,
  parameter int DEPTH      = 4,
  parameter int NU         = 4,
  parameter int ADDR_W     = 9,
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic [NU-1:0]     irq_o
);
  localparam int NB = 2 * NQ;
  localparam int CW = $clog2(DEPTH + 1);

  reg_sel_t sel;
  logic     busy, wr_ok, rd_pop, cfg_we, srst_start, clr_all;
  logic     cfg_auto;
  logic [1:0] cfg_idle;

  logic [NQ-1:0]          q_push, q_pop, q_ev_new, q_ev_free;
  logic [NQ-1:0][31:0]    q_head;
  logic [NQ-1:0][CW-1:0]  q_cnt;
  logic [NQ-1:0]          q_full, q_empty;
  logic [NB-1:0]          ev;
  logic [NU-1:0]          st_we, en_we;
  logic [NU-1:0][NB-1:0]  u_st, u_en;

  assign sel        = decode(16'(addr), NQ, NU);
  assign wr_ok      = wr_en && !busy;                  // R10: writes ignored while busy
  assign rd_pop     = rd_en && !wr_en && !busy;        // R11: write wins, no pop
  assign cfg_we     = wr_ok && (sel.kind == RG_CFG);
  assign srst_start = cfg_we && wr_data[1];
  assign clr_all    = srst_start || busy;

  mbox_srst #(.CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_auto <= 1'b0;
      cfg_idle <= 2'b00;
    end else if (clr_all) begin
      cfg_auto <= 1'b0;
      cfg_idle <= 2'b00;
    end else if (cfg_we) begin
      cfg_auto <= wr_data[0];
      cfg_idle <= wr_data[4:3];
    end
  end

  for (genvar m = 0; m < NQ; m++) begin : g_q
    assign q_push[m] = wr_ok  && (sel.kind == RG_MSG) && (int'(sel.idx) == m);
    assign q_pop[m]  = rd_pop && (sel.kind == RG_MSG) && (int'(sel.idx) == m);
    mbox_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .push(q_push[m]), .pop(q_pop[m]), .din(wr_data),
      .head(q_head[m]), .count(q_cnt[m]), .full(q_full[m]), .empty(q_empty[m]),
      .went_nonempty(q_ev_new[m]), .left_full(q_ev_free[m])
    );
  end

  // R5/R6: interleave queue events into the shared status layout
  always_comb begin
    ev = '0;
    for (int m = 0; m < NQ; m++) begin
      ev[newmsg_bit(m)]  = q_ev_new[m];
      ev[notfull_bit(m)] = q_ev_free[m];
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    assign st_we[u] = wr_ok && (sel.kind == RG_IST) && (int'(sel.idx) == u);
    assign en_we[u] = wr_ok && (sel.kind == RG_IEN) && (int'(sel.idx) == u);
    mbox_user_irq #(.NB(NB)) u_irq (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .ev(ev),
      .st_we(st_we[u]), .en_we(en_we[u]), .wdata(wr_data[NB-1:0]),
      .st(u_st[u]), .en(u_en[u]), .irq(irq_o[u])
    );
  end

  // read mux (R1, R3, R8, R10, R11)
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (sel.kind)
        RG_REV: rd_data = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
        RG_CFG: rd_data = {27'd0, cfg_idle, 2'b00, cfg_auto};
        RG_STS: rd_data = {31'd0, !busy};
        default: begin
          for (int m = 0; m < NQ; m++) begin
            if (int'(sel.idx) == m) begin
              if (sel.kind == RG_MSG)  rd_data = q_head[m];
              if (sel.kind == RG_FULL) rd_data = {31'd0, q_full[m]};
              if (sel.kind == RG_CNT)  rd_data = 32'(q_cnt[m]);
            end
          end
          for (int u = 0; u < NU; u++) begin
            if (int'(sel.idx) == u) begin
              if (sel.kind == RG_IST) rd_data = 32'(u_st[u]);
              if (sel.kind == RG_IEN) rd_data = 32'(u_en[u]);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mbox_regblk_chk.sv
module mbox_regblk_chk #(
  parameter int NQ    = 4,
  parameter int DEPTH = 4,
  parameter int NU    = 4
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    busy,
  input logic                                    clr_all,
  input logic [NQ-1:0]                           q_push,
  input logic [NQ-1:0]                           q_pop,
  input logic [NQ-1:0][$clog2(DEPTH+1)-1:0]      q_cnt,
  input logic [NU-1:0]                           st_we,
  input logic [NU-1:0][2*NQ-1:0]                 u_st,
  input logic [NU-1:0][2*NQ-1:0]                 u_en,
  input logic [NU-1:0]                           irq_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  for (genvar m = 0; m < NQ; m++) begin : g_qa
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt[m] <= FULL_CNT);
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push[m] && q_cnt[m] == FULL_CNT) |=> (q_cnt[m] == FULL_CNT));
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop[m] && q_cnt[m] == '0) |=> (q_cnt[m] == '0));
    for (genvar u = 0; u < NU; u++) begin : g_ua
      assert_newmsg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push[m] && q_cnt[m] == '0) |=> u_st[u][2*m]);
      assert_notfull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop[m] && q_cnt[m] == FULL_CNT) |=> u_st[u][2*m+1]);
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_usr
    assert_sticky_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_we[u] && !clr_all) |=> ((u_st[u] & $past(u_st[u])) == $past(u_st[u])));
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (u_en[u] == '0) |-> !irq_o[u]);
  end

  assert_srst_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (u_st == '0 && u_en == '0 && q_cnt == '0));
endmodule

bind mbox_regblk mbox_regblk_chk #(.NQ(NQ), .DEPTH(DEPTH), .NU(NU)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .clr_all(clr_all),
  .q_push(q_push), .q_pop(q_pop), .q_cnt(q_cnt),
  .st_we(st_we), .u_st(u_st), .u_en(u_en), .irq_o(irq_o)
);

// File: tb/mbox_regblk_test.sv
module mbox_regblk_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  addr;
  logic        wr_en, rd_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  irq_o;

  always #10 clk = ~clk;   // 50 MHz

  mbox_regblk uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference model
  bit [31:0] mq [4][$];
  bit [7:0]  m_st [4];
  bit [7:0]  m_en [4];
  bit        m_auto;
  bit [1:0]  m_idle;
  int        m_rcnt;

  function automatic void model_clear();
    for (int k = 0; k < 4; k++) begin
      mq[k].delete(); m_st[k] = 0; m_en[k] = 0;
    end
    m_auto = 0; m_idle = 0;
  endfunction

  function automatic logic [31:0] exp_rd(input int o);
    int k;
    if (o % 4 != 0) return 0;
    if (o == 0)  return 32'h21;
    if (o == 16) return {27'd0, m_idle, 2'b00, m_auto};
    if (o == 20) return (m_rcnt == 0) ? 32'd1 : 32'd0;
    if (o >= 64 && o < 80)   begin k = (o - 64) / 4;  return mq[k].size() > 0 ? mq[k][0] : 0; end
    if (o >= 128 && o < 144) begin k = (o - 128) / 4; return mq[k].size() == 4 ? 1 : 0; end
    if (o >= 192 && o < 208) begin k = (o - 192) / 4; return 32'(mq[k].size()); end
    if (o >= 256 && o < 288) begin
      k = (o - 256) / 8;
      return (o % 8 == 0) ? {24'd0, m_st[k]} : {24'd0, m_en[k]};
    end
    return 0;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int u = 0; u < 4; u++) v[u] = |(m_st[u] & m_en[u]);
    return v;
  endfunction

  function automatic void model_edge(input bit w, input bit r, input int o, input logic [31:0] d);
    bit [7:0] evts = 0;
    int k;
    if (m_rcnt > 0) begin
      m_rcnt--;
      return;
    end
    if (w) begin
      if (o % 4 == 0) begin
        if (o == 16) begin
          if (d[1]) begin model_clear(); m_rcnt = 4; end
          else begin m_auto = d[0]; m_idle = d[4:3]; end
        end else if (o >= 64 && o < 80) begin
          k = (o - 64) / 4;
          if (mq[k].size() < 4) begin
            if (mq[k].size() == 0) evts[2*k] = 1'b1;
            mq[k].push_back(d);
          end
        end else if (o >= 256 && o < 288) begin
          k = (o - 256) / 8;
          if (o % 8 == 0) m_st[k] = m_st[k] & ~d[7:0];
          else            m_en[k] = d[7:0];
        end
      end
    end else if (r && o % 4 == 0 && o >= 64 && o < 80) begin
      k = (o - 64) / 4;
      if (mq[k].size() > 0) begin
        if (mq[k].size() == 4) evts[2*k+1] = 1'b1;
        void'(mq[k].pop_front());
      end
    end
    for (int u = 0; u < 4; u++) m_st[u] = m_st[u] | evts;
  endfunction

  // one bus cycle, starting just after a falling edge
  task automatic step(input bit w, input bit r, input int o, input logic [31:0] d, input string tag);
    logic [31:0] e;
    logic [3:0]  ei;
    wr_en = w; rd_en = r; addr = 9'(o); wr_data = d;
    #4;
    e  = exp_rd(o);
    ei = exp_irq();
    if (r) begin
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s read @%03h: got %08h expected %08h", tag, o, rd_data, e);
      end
    end
    checks++;
    if (irq_o !== ei) begin
      fails++;
      $display("FAIL R9 (%s) irq: got %b expected %b", tag, irq_o, ei);
    end
    @(posedge clk);
    model_edge(w, r, o, d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input int o, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, o, d, tag);
  endtask

  task automatic rd(input int o, input string tag);
    step(1'b0, 1'b1, o, 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned lf;
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
    model_clear(); m_rcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd('h000, "R1"); rd('h014, "R1"); rd('h010, "R1");
    for (int k = 0; k < 4; k++) begin
      rd('h0C0 + 4*k, "R1"); rd('h080 + 4*k, "R1"); rd('h100 + 8*k, "R1"); rd('h104 + 8*k, "R1");
    end

    // R8 enables: queue0 new-message to user1, queue0 not-full to user0
    wr('h10C, 32'h0000_0001, "R8"); rd('h10C, "R8");
    wr('h104, 32'h0000_0002, "R8"); rd('h104, "R8");
    wr('h11C, 32'hFFFF_FFFF, "R8"); rd('h11C, "R8");
    wr('h11C, 32'h0, "R8");

    // R2/R3/R4/R5: fill queue 0 past full
    for (int i = 0; i < 5; i++) begin
      wr('h040, 32'hA000_0000 + 32'(i), "R4");
      rd('h0C0, "R3"); rd('h080, "R3"); rd('h100, "R5");
    end
    // R6/R2: drain in order, then read empty
    for (int i = 0; i < 4; i++) begin
      rd('h040, "R2"); rd('h0C0, "R3"); rd('h10C, "R6");
    end
    rd('h040, "R4"); rd('h0C0, "R4");

    // R7 write-one-to-clear
    wr('h108, 32'h0000_0002, "R7"); rd('h108, "R7");
    wr('h108, 32'h0000_0000, "R7"); rd('h108, "R7");
    wr('h108, 32'hFFFF_FFFF, "R7"); rd('h108, "R7");
    wr('h100, 32'h0000_0001, "R7"); rd('h100, "R9");

    // other queues
    wr('h04C, 32'h1234_5678, "R5"); wr('h044, 32'h0BAD_F00D, "R5");
    rd('h118, "R5"); rd('h04C, "R2"); rd('h044, "R2"); rd('h0CC, "R3");

    // R11 unmapped, misaligned, simultaneous write+read
    wr('h042, 32'h5555_5555, "R11"); rd('h042, "R11"); rd('h0C0, "R11");
    wr('h020, 32'hFFFF_FFFF, "R11"); rd('h020, "R11"); rd('h120, "R11");
    step(1'b1, 1'b1, 'h048, 32'hCAFE_0001, "R11"); rd('h0C8, "R11");

    // R10 configuration and soft reset
    wr('h010, 32'h0000_001B, "R10"); rd('h010, "R10");
    wr('h10C, 32'h0000_00FF, "R10");
    wr('h010, 32'h0000_0002, "R10");
    rd('h014, "R10"); wr('h040, 32'h7, "R10"); rd('h014, "R10"); rd('h014, "R10");
    rd('h014, "R10"); rd('h014, "R10");
    rd('h010, "R10"); rd('h0C8, "R10"); rd('h0C0, "R10"); rd('h10C, "R10"); rd('h100, "R10");

    // random traffic compared every cycle
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 1500; i++) begin
      int sel, k, o;
      bit w;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      sel = int'(lf % 8); k = int'((lf >> 4) % 4); w = lf[9];
      case (sel)
        0, 1: o = 'h040 + 4*k;
        2:    o = 'h0C0 + 4*k;
        3:    o = 'h080 + 4*k;
        4:    o = 'h100 + 8*k;
        5:    o = 'h104 + 8*k;
        6:    o = 'h014;
        default: o = 'h000;
      endcase
      if (sel == 4 || sel == 5) w = lf[10] & lf[11];
      step(w, !w, o, lf ^ 32'h9E37_79B9, "R2");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule